// File: doc/BRIEF.md
# Multiplexed Channel Scan Sequencer

This block drives a shared converter that sits behind an analog multiplexer and a programmable-gain stage. It walks a fixed list of channel slots. For each slot it presents a multiplexer select and a gain code. It then lets the analog path settle for a number of clock cycles that each slot sets on its own. Next it throws away a programmable number of conversions, so that charge left over from the previous channel cannot leak into a result. The conversion after those becomes an output word. Each word is tagged with the slot index and gain code and handed on through a valid/ready handshake.

Back-pressure freezes the scan in place, so an accepted word is never overwritten. Two free-running counters report how many multiplexer hops have happened and how many conversions were thrown away.

A calibration request can be raised at any time, for example at power-up self-test, at a scheduled checkpoint, after service or after a reagent lot change. The request is latched and runs as an extra slot at the next slot boundary. During that slot an injection switch is closed so a known level is applied. The accepted conversion is compared with an expected value, and the size of the difference is checked against a limit. The result is reported as pass or fail together with the signed residual. The regular scan then resumes at the entry it would have visited next.

Top module: `scan_sequencer`

## Requirements
- R1: Regular slots visit entries 0, 1, …, NCH-1 and then wrap to 0. `mux_sel` and `gain_code` always show the fields of the current slot's entry. An output word's `out_chan` equals the index of the entry that produced it, and `out_gain` equals that entry's gain code.
- R2: Each slot starts with one hop cycle, followed by exactly S settle cycles, where S is the slot's settle count (S = 0 is allowed). A conversion that arrives during the hop cycle or a settle cycle is counted as discarded and is never forwarded.
- R3: After settling, the next max(1, D) conversions are discarded, where D is the slot's discard count. A discard count of 0 therefore still throws one conversion away.
- R4: `sw_count` rises by one in the cycle after every hop cycle, including hops into the calibration slot. It wraps modulo 2^CNT_W and is 0 after reset.
- R5: `disc_count` rises by one for every conversion discarded under R2 or R3, one cycle after that conversion. It wraps modulo 2^CNT_W.
- R6: The first conversion after the discards of a regular slot is registered as an output word: `out_data` holds the conversion and `out_valid` goes high in the next cycle.
- R7: While `out_valid` is high and `out_ready` is low, the word, the slot and both counters hold. Conversions that arrive in that state are ignored and not counted. The cycle after `out_ready` is seen high is the hop cycle of the next slot.
- R8: A `cal_req` pulse is latched. At the next slot boundary the calibration slot runs. In that slot `inj_en` is 1, `mux_sel` shows `cal_sel`, `gain_code` shows `cal_gain`, and settle and discard follow `cal_settle` and `cal_discard`. Afterwards the scan continues with the regular entry that follows the last one output. The calibration sample never appears on the output stream.
- R9: The accepted calibration conversion produces residual = `adc_data` − `cal_expect` as a signed DATA_W+1-bit value. `cal_pass` is 1 exactly when |residual| ≤ `cal_limit`. `cal_done` pulses for one cycle, one cycle after that conversion. `cal_pass` and `cal_resid` hold until the next calibration completes.
- R10: During reset the sequencer is in the hop cycle of entry 0 with no calibration pending. `out_valid`, `inj_en`, `cal_done` and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | NCH*SEL_W | Multiplexer select per entry, entry i at bits i*SEL_W |
| cfg_gain | input | NCH*GAIN_W | Gain code per entry |
| cfg_settle | input | NCH*SETTLE_W | Settle cycles per entry |
| cfg_discard | input | NCH*DISC_W | Conversions to discard per entry (0 acts as 1) |
| cal_req | input | 1 | Request a calibration slot |
| cal_sel | input | SEL_W | Multiplexer select during calibration |
| cal_gain | input | GAIN_W | Gain code during calibration |
| cal_settle | input | SETTLE_W | Settle cycles for the calibration slot |
| cal_discard | input | DISC_W | Discard count for the calibration slot |
| cal_expect | input | DATA_W | Expected value of the injected level |
| cal_limit | input | DATA_W | Largest accepted residual magnitude |
| mux_sel | output | SEL_W | Multiplexer select |
| gain_code | output | GAIN_W | Gain-stage code |
| inj_en | output | 1 | Injection switch closed |
| adc_valid | input | 1 | A conversion is present this cycle |
| adc_data | input | DATA_W | Conversion value |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_chan | output | CH_W | Entry index of the word |
| out_gain | output | GAIN_W | Gain code of the word |
| out_data | output | DATA_W | Sample value of the word |
| sw_count | output | CNT_W | Total multiplexer hops |
| disc_count | output | CNT_W | Total discarded conversions |
| cal_done | output | 1 | Calibration result is new this cycle |
| cal_pass | output | 1 | Last calibration within limit |
| cal_resid | output | DATA_W+1 | Last signed residual |

## Verification
The bench builds the sequencer with three entries and 8-bit data. The entries use settle counts of 3, 0 and 5 and discard counts of 2, 1 and 0. This covers the zero-settle path, the path where a discard count of 0 is raised to 1, and a longer settle window within a few thousand cycles. The counters are 8 bits wide, so both wrap many times during the run. Conversions that land on the calibration slot are drawn from a narrow band around the expected value, so residuals exactly at the limit and one step beyond it both occur. Back-to-back calibration requests and long stalls on `out_ready` also occur.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int NCH      = 4,
  parameter int SEL_W    = 3,
  parameter int GAIN_W   = 2,
  parameter int DATA_W   = 16,
  parameter int SETTLE_W = 8,
  parameter int DISC_W   = 4,
  parameter int CNT_W    = 16,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH*SEL_W-1:0]     cfg_sel,
  input  logic [NCH*GAIN_W-1:0]    cfg_gain,
  input  logic [NCH*SETTLE_W-1:0]  cfg_settle,
  input  logic [NCH*DISC_W-1:0]    cfg_discard,
  input  logic                     cal_req,
  input  logic [SEL_W-1:0]         cal_sel,
  input  logic [GAIN_W-1:0]        cal_gain,
  input  logic [SETTLE_W-1:0]      cal_settle,
  input  logic [DISC_W-1:0]        cal_discard,
  input  logic [DATA_W-1:0]        cal_expect,
  input  logic [DATA_W-1:0]        cal_limit,
  output logic [SEL_W-1:0]         mux_sel,
  output logic [GAIN_W-1:0]        gain_code,
  output logic                     inj_en,
  input  logic                     adc_valid,
  input  logic [DATA_W-1:0]        adc_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [CH_W-1:0]          out_chan,
  output logic [GAIN_W-1:0]        out_gain,
  output logic [DATA_W-1:0]        out_data,
  output logic [CNT_W-1:0]         sw_count,
  output logic [CNT_W-1:0]         disc_count,
  output logic                     cal_done,
  output logic                     cal_pass,
  output logic [DATA_W:0]          cal_resid
);

  typedef enum logic [2:0] {S_HOP, S_SETTLE, S_DISC, S_ACQ, S_HOLD} st_t;
  localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

  st_t                st;
  logic [CH_W-1:0]    idx;
  logic               cal_active, cal_pend;
  logic [SETTLE_W-1:0] scnt;
  logic [DISC_W-1:0]  dcnt;

  logic [SETTLE_W-1:0] slot_settle;
  logic [DISC_W-1:0]   slot_disc;
  logic signed [DATA_W:0] resid;
  logic [DATA_W:0]     resid_mag;

  assign mux_sel     = cal_active ? cal_sel     : cfg_sel[idx*SEL_W +: SEL_W];
  assign gain_code   = cal_active ? cal_gain    : cfg_gain[idx*GAIN_W +: GAIN_W];
  assign slot_settle = cal_active ? cal_settle  : cfg_settle[idx*SETTLE_W +: SETTLE_W];
  assign slot_disc   = cal_active ? cal_discard : cfg_discard[idx*DISC_W +: DISC_W];
  assign inj_en      = cal_active;

  assign resid     = $signed({1'b0, adc_data}) - $signed({1'b0, cal_expect});
  assign resid_mag = resid[DATA_W] ? DATA_W'(0) - resid : resid;

  wire pend_now = cal_pend | cal_req;
  wire take_next = (st == S_HOLD && out_ready) || (st == S_ACQ && adc_valid && cal_active);
  wire disc_evt = adc_valid && (st == S_HOP || st == S_SETTLE || st == S_DISC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_HOP;
      idx        <= '0;
      cal_active <= 1'b0;
      cal_pend   <= 1'b0;
      scnt       <= '0;
      dcnt       <= '0;
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_gain   <= '0;
      out_data   <= '0;
      sw_count   <= '0;
      disc_count <= '0;
      cal_done   <= 1'b0;
      cal_pass   <= 1'b0;
      cal_resid  <= '0;
    end else begin
      cal_done <= 1'b0;
      cal_pend <= take_next ? 1'b0 : pend_now;
      if (disc_evt) disc_count <= disc_count + 1'b1;
      case (st)
        S_HOP: begin
          sw_count <= sw_count + 1'b1;
          dcnt     <= (slot_disc == '0) ? DISC_W'(1) : slot_disc;
          if (slot_settle == '0) st <= S_DISC;
          else begin
            scnt <= slot_settle - 1'b1;
            st   <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (scnt == '0) st <= S_DISC;
          else scnt <= scnt - 1'b1;
        end
        S_DISC: if (adc_valid) begin
          dcnt <= dcnt - 1'b1;
          if (dcnt == DISC_W'(1)) st <= S_ACQ;
        end
        S_ACQ: if (adc_valid) begin
          if (cal_active) begin
            cal_done   <= 1'b1;
            cal_resid  <= resid;
            cal_pass   <= resid_mag <= {1'b0, cal_limit};
            cal_active <= pend_now;
            st         <= S_HOP;
          end else begin
            out_valid <= 1'b1;
            out_chan  <= idx;
            out_gain  <= gain_code;
            out_data  <= adc_data;
            st        <= S_HOLD;
          end
        end
        S_HOLD: if (out_ready) begin
          out_valid  <= 1'b0;
          idx        <= (idx == LAST) ? '0 : idx + 1'b1;
          cal_active <= pend_now;
          st         <= S_HOP;
        end
        default: st <= S_HOP;
      endcase
    end
  end

  a_r7_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_gain));

  a_r7_scan_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(sw_count) && $stable(disc_count) && $stable(mux_sel));

  a_r8_inject_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    inj_en |-> !out_valid);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  a_r6_word_from_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(adc_valid));

  a_r2_no_word_in_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE) |-> !out_valid && !cal_done || $past(st) == S_ACQ);

endmodule

// File: tb/test_scan_sequencer.sv
module test_scan_sequencer;
  localparam int NCH = 3, SEL_W = 3, GAIN_W = 2, DATA_W = 8;
  localparam int SETTLE_W = 4, DISC_W = 3, CNT_W = 8, CH_W = 2;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cal_req = 1'b0, adc_valid = 1'b0, out_ready = 1'b0;
  logic [DATA_W-1:0] adc_data = '0;
  logic [SEL_W-1:0] mux_sel;
  logic [GAIN_W-1:0] gain_code, out_gain;
  logic inj_en, out_valid, cal_done, cal_pass;
  logic [CH_W-1:0] out_chan;
  logic [DATA_W-1:0] out_data;
  logic [CNT_W-1:0] sw_count, disc_count;
  logic [DATA_W:0] cal_resid;

  int sel_t[NCH]  = '{5, 2, 7};
  int gain_t[NCH] = '{1, 3, 0};
  int set_t[NCH]  = '{3, 0, 5};
  int dis_t[NCH]  = '{2, 1, 0};
  localparam int CSEL = 4, CGAIN = 2, CSET = 2, CDIS = 1, CEXP = 100, CLIM = 3;

  scan_sequencer #(.NCH(NCH), .SEL_W(SEL_W), .GAIN_W(GAIN_W), .DATA_W(DATA_W),
    .SETTLE_W(SETTLE_W), .DISC_W(DISC_W), .CNT_W(CNT_W)) i_scan_sequencer (
    .clk(clk), .rst_n(rst_n),
    .cfg_sel({3'd7, 3'd2, 3'd5}), .cfg_gain({2'd0, 2'd3, 2'd1}),
    .cfg_settle({4'd5, 4'd0, 4'd3}), .cfg_discard({3'd0, 3'd1, 3'd2}),
    .cal_req(cal_req), .cal_sel(3'(CSEL)), .cal_gain(2'(CGAIN)),
    .cal_settle(4'(CSET)), .cal_discard(3'(CDIS)),
    .cal_expect(8'(CEXP)), .cal_limit(8'(CLIM)),
    .mux_sel(mux_sel), .gain_code(gain_code), .inj_en(inj_en),
    .adc_valid(adc_valid), .adc_data(adc_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_gain(out_gain), .out_data(out_data),
    .sw_count(sw_count), .disc_count(disc_count),
    .cal_done(cal_done), .cal_pass(cal_pass), .cal_resid(cal_resid));

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 hop, 1 settle, 2 discard, 3 accept, 4 hold
  int m_ph = 0, m_idx = 0, m_cal = 0, m_pend = 0, m_sleft = 0, m_dleft = 0;
  int m_sw = 0, m_dc = 0, m_ov = 0, m_oc = 0, m_og = 0, m_od = 0;
  int m_done = 0, m_pass = 0, m_res = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_cal = 0; m_pend = 0; m_sw = 0; m_dc = 0;
      m_ov = 0; m_oc = 0; m_og = 0; m_od = 0; m_done = 0; m_pass = 0; m_res = 0;
    end else begin
      int pn, taken, st, dc;
      pn = m_pend | int'(cal_req);
      taken = 0;
      m_done = 0;
      if (m_ph <= 2 && adc_valid) m_dc = (m_dc + 1) % 256;
      case (m_ph)
        0: begin
          st = m_cal ? CSET : set_t[m_idx];
          dc = m_cal ? CDIS : dis_t[m_idx];
          m_sw = (m_sw + 1) % 256;
          m_sleft = st;
          m_dleft = (dc == 0) ? 1 : dc;
          m_ph = (st == 0) ? 2 : 1;
        end
        1: begin
          m_sleft--;
          if (m_sleft == 0) m_ph = 2;
        end
        2: if (adc_valid) begin
          m_dleft--;
          if (m_dleft == 0) m_ph = 3;
        end
        3: if (adc_valid) begin
          if (m_cal) begin
            m_res = int'(adc_data) - CEXP;
            m_pass = ((m_res < 0 ? -m_res : m_res) <= CLIM);
            m_done = 1;
            m_cal = pn; taken = 1; m_ph = 0;
          end else begin
            m_ov = 1; m_oc = m_idx; m_og = gain_t[m_idx]; m_od = int'(adc_data);
            m_ph = 4;
          end
        end
        default: if (out_ready) begin
          m_ov = 0; m_idx = (m_idx + 1) % NCH;
          m_cal = pn; taken = 1; m_ph = 0;
        end
      endcase
      m_pend = taken ? 0 : pn;
    end
  end

  int seen_pass = 0, seen_fail = 0, seen_wrap = 0, seen_ch2 = 0, seen_chg = 0;
  int prev_sw = 0, stall = 0;
  bit hung = 0;

  task automatic compare_all();
    check(int'(mux_sel) == (m_cal ? CSEL : sel_t[m_idx]), "R1 mux_sel", int'(mux_sel), m_cal ? CSEL : sel_t[m_idx]);
    check(int'(gain_code) == (m_cal ? CGAIN : gain_t[m_idx]), "R1 gain_code", int'(gain_code), m_cal ? CGAIN : gain_t[m_idx]);
    check(int'(inj_en) == m_cal, "R8 inj_en", int'(inj_en), m_cal);
    check(int'(out_valid) == m_ov, "R6/R7 out_valid", int'(out_valid), m_ov);
    if (m_ov) begin
      check(int'(out_chan) == m_oc, "R1 out_chan", int'(out_chan), m_oc);
      check(int'(out_gain) == m_og, "R1 out_gain", int'(out_gain), m_og);
      check(int'(out_data) == m_od, "R6 out_data", int'(out_data), m_od);
    end
    check(int'(sw_count) == m_sw, "R4 sw_count", int'(sw_count), m_sw);
    check(int'(disc_count) == m_dc, "R5/R2/R3 disc_count", int'(disc_count), m_dc);
    check(int'(cal_done) == m_done, "R9 cal_done", int'(cal_done), m_done);
    if (m_done) begin
      check(int'(cal_pass) == m_pass, "R9 cal_pass", int'(cal_pass), m_pass);
      check(int'($signed(cal_resid)) == m_res, "R9 cal_resid", int'($signed(cal_resid)), m_res);
      if (m_pass) seen_pass++; else seen_fail++;
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0 && inj_en == 1'b0 && cal_done == 1'b0, "R10 flags", int'(out_valid), 0);
      check(sw_count == '0 && disc_count == '0, "R10 counters", int'(sw_count), 0);
      check(int'(mux_sel) == sel_t[0], "R10 entry 0", int'(mux_sel), sel_t[0]);
    end
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC && !hung; cyc++) begin
      @(negedge clk);
      compare_all();
      if (int'(sw_count) < prev_sw) seen_wrap = 1;
      prev_sw = int'(sw_count);
      if (out_valid && out_chan == 2'd2) seen_ch2 = 1;
      if (m_cal && m_ph == 0 && m_idx != 0) seen_chg = 1;
      if (out_valid && out_ready) stall = 0; else stall++;
      if (stall > 2000) begin
        hung = 1;
        check(1'b0, "watchdog", stall, 0);
      end
      // R8: requests, including two in a row
      cal_req = ((cyc % 157) == 20) || (cyc == 1500) || (cyc == 1501);
      if (cyc < 1200) begin
        adc_valid = 1'b1;
        out_ready = 1'b1;
      end else if (cyc < 2800) begin
        adc_valid = 1'($urandom % 2);
        out_ready = 1'($urandom % 2);
      end else begin
        adc_valid = (cyc % 4) == 0;
        out_ready = ((cyc / 40) % 2) == 0;   // R7 long stalls
      end
      if (m_cal) adc_data = 8'(96 + ($urandom % 9));
      else adc_data = 8'($urandom);
    end
    check(seen_pass > 0 && seen_fail > 0, "R9 both outcomes seen", seen_pass, seen_fail);
    check(seen_wrap == 1, "R4 counter wrap seen", seen_wrap, 1);
    check(seen_ch2 == 1, "R3 zero-discard entry produced a word", seen_ch2, 1);
    check(seen_chg == 1, "R8 calibration mid-scan", seen_chg, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule